// File: doc/BRIEF.md
# Windowed-change watchdog timer

This block is a watchdog timer for a processor subsystem. A counter advances on ticks of a slow time base, delivered as a single-cycle enable synchronous to the system clock. One of ten power-of-two time-out lengths is selected. Software must pulse the restart strobe before the selected length runs out. If it does not, the block takes the action it is configured for: an interrupt, a system reset request, or an interrupt first and then a reset on the following expiry. The interrupt-first mode gives software one period to save state before the reset arrives.

The time-out length can only be changed, and reset mode can only be turned off, through a guarded two-write sequence. The first write arms a short window. A second write inside that window applies the new settings. A fuse input locks the block into reset mode. A separate cause register captures the watchdog, brown-out, external and power-on reset events, and software clears each flag by writing a one to it. The register holding the settings takes a reset only from the register reset input. The block's own reset request does not clear it, so the watchdog stays enabled after a reset it has caused.

Top module: `wdog_core`

## Requirements
- R1: After register reset with the fuse off, the control register reads 0x00, the cause register reads 0x0, and irqOut and sysRst are low.
- R2: The control register holds the time-out select in bits 3:0. Code k (0 to 9) sets a time-out of 2^(BASE_LOG2+k) ticks, so at the default BASE_LOG2 of 11, code 0 is 2K and code 5 is 64K. Codes 10 to 15 act as code 9. The counter advances only in cycles where tickEn is high.
- R3: A kick clears the counter. A kick in the same cycle as the final tick prevents that expiry, and a full time-out is then needed again.
- R4: When interrupt enable (bit 4) is set and an expiry occurs, the pending flag (bit 7) is set and irqOut follows it. Writing a one to bit 7 clears the flag, and the clear loses to a new expiry in the same cycle.
- R5: When the block is in reset mode (bit 5 set, bit 4 clear) and an expiry occurs, sysRst pulses high for exactly one cycle and the watchdog cause flag is set. Reset enable stays 1 and counting resumes from zero.
- R6: With bits 4 and 5 both set, the first expiry raises the interrupt and hardware clears bit 4. The next expiry then pulses sysRst.
- R7: With bits 4 and 5 both clear, the counter is held at zero and neither an interrupt nor a reset occurs.
- R8: A single write with change enable (bit 6) and bit 5 both set arms a window. Bit 6 then reads 1 for the next four clocks and clears itself when the window ends.
- R9: While the window is open, a write with bit 6 clear loads bit 5 and bits 3:0 from the write data and closes the window.
- R10: Outside the window, writes leave bits 3:0 unchanged and cannot clear bit 5, although they can set it. Bit 4 is always written directly.
- R11: While fuseOn is high, bit 5 reads 1 and bit 4 reads 0, and no write changes either bit. Any expiry then resets.
- R12: The cause register holds the watchdog flag in bit 3, brown-out in bit 2, external in bit 1 and power-on in bit 0. An event sets its flag, a one written to a flag bit clears it, and a set wins over a clear in the same cycle.
- R13: If a shorter time-out is selected while the count is already past the new limit, the next tick expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low register reset |
| tickEn | input | 1 | One-cycle tick of the slow watchdog time base |
| kick | input | 1 | Restart strobe, clears the counter |
| fuseOn | input | 1 | Always-on fuse, forces reset mode |
| ctlWr | input | 1 | Write strobe for the control register |
| ctlWdata | input | 8 | Control write data |
| ctlRdata | output | 8 | Control register readback |
| causeWr | input | 1 | Write strobe for the cause register (write one to clear) |
| causeWdata | input | 4 | Cause write data |
| causeRdata | output | 4 | Cause register readback |
| borEvt | input | 1 | Brown-out reset event |
| extEvt | input | 1 | External reset event |
| porEvt | input | 1 | Power-on reset event |
| irqOut | output | 1 | Watchdog interrupt, level |
| sysRst | output | 1 | One-cycle system reset request |

## Verification
The bench targets the edges of the guarded window. It applies a confirming write on the last open clock and another just after the window has closed. A design with an off-by-one window would either accept a late select or drop a valid one. It checks a kick that lands on the final tick, which a design that lets the expiry win would turn into a spurious interrupt. It checks the second expiry of interrupt-then-reset mode, which a design that does not clear interrupt enable would turn into a repeated interrupt instead of a reset. It also drives select codes above nine and switches to a shorter time-out past the current count. A design without clamping would never expire in the first case, and one comparing for equality would wrap through the whole counter range in the second.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W   = 4;
  localparam int CTL_W   = 8;
  localparam int CAUSE_W = 4;

  // control register field positions
  localparam int SEL_LSB = 0;
  localparam int INT_BIT = 4;
  localparam int RST_BIT = 5;
  localparam int CHG_BIT = 6;
  localparam int IRQ_BIT = 7;

  // cause register flag positions
  localparam int WD_FLAG  = 3;
  localparam int BOR_FLAG = 2;
  localparam int EXT_FLAG = 1;
  localparam int POR_FLAG = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic run;      // watchdog enabled in some mode
    logic restart;  // clear the counter this cycle
  } dpCmd_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int NUM_TAPS  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  dpCmd_t           cmd,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  localparam int CNT_W = BASE_LOG2 + NUM_TAPS - 1;

  logic [CNT_W-1:0]    cntQ;
  logic [NUM_TAPS-1:0] hit;
  logic [SEL_W-1:0]    selIdx;
  logic                hitSel;

  // one comparator per tap; >= so a shorter tap fires at once
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam logic [CNT_W-1:0] LAST = CNT_W'((64'd1 << (BASE_LOG2 + i)) - 64'd1);
    assign hit[i] = (cntQ >= LAST);
  end

  // codes past the last tap use the longest one
  assign selIdx = (sel > SEL_W'(NUM_TAPS - 1)) ? SEL_W'(NUM_TAPS - 1) : sel;

  always_comb begin
    hitSel = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (selIdx == SEL_W'(i)) hitSel = hit[i];
    end
  end

  assign expire = cmd.run & tickEn & ~cmd.restart & hitSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (!cmd.run || cmd.restart || expire) begin
      cntQ <= '0;
    end else if (tickEn) begin
      cntQ <= cntQ + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int WIN_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fuseOn,
  input  logic             kick,
  input  logic             ctlWr,
  input  logic [CTL_W-1:0] ctlWdata,
  input  logic             expire,
  output dpCmd_t           cmd,
  output logic [SEL_W-1:0] sel,
  output logic [CTL_W-1:0] ctlRdata,
  output logic             irqOut,
  output logic             sysRst,
  output logic             wdSet
);
  localparam int WC_W = $clog2(WIN_LEN + 1);

  logic [SEL_W-1:0] selQ;
  logic [WC_W-1:0]  winCntQ;
  logic             intEnQ, rstEnQ, irqFlagQ, sysRstQ;
  logic             effInt, effRst, winOpen;
  logic             wrArm, wrFinal, fireIrq, escalate, fireRst;

  always_comb begin
    effInt   = intEnQ & ~fuseOn;
    effRst   = rstEnQ | fuseOn;
    winOpen  = (winCntQ != '0);
    wrArm    = ctlWr & ctlWdata[CHG_BIT] & ctlWdata[RST_BIT];
    wrFinal  = ctlWr & ~ctlWdata[CHG_BIT] & winOpen;
    fireIrq  = expire & effInt;
    escalate = fireIrq & effRst;
    fireRst  = expire & effRst & ~effInt;
  end

  assign cmd    = '{run: effInt | effRst, restart: kick};
  assign sel    = selQ;
  assign irqOut = irqFlagQ;
  assign sysRst = sysRstQ;
  assign wdSet  = fireRst;

  always_comb begin
    ctlRdata                      = '0;
    ctlRdata[SEL_LSB +: SEL_W]    = selQ;
    ctlRdata[INT_BIT]             = effInt;
    ctlRdata[RST_BIT]             = effRst;
    ctlRdata[CHG_BIT]             = winOpen;
    ctlRdata[IRQ_BIT]             = irqFlagQ;
  end

  // change window: armed by the first write, closed by the second or by time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCntQ <= '0;
    end else if (wrArm) begin
      winCntQ <= WC_W'(WIN_LEN);
    end else if (wrFinal) begin
      winCntQ <= '0;
    end else if (winOpen) begin
      winCntQ <= winCntQ - WC_W'(1);
    end
  end

  // protected fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= '0;
      rstEnQ <= 1'b0;
    end else begin
      if (wrFinal) selQ <= ctlWdata[SEL_LSB +: SEL_W];
      if (fuseOn) begin
        rstEnQ <= 1'b1;
      end else if (wrFinal) begin
        rstEnQ <= ctlWdata[RST_BIT];
      end else if (ctlWr && ctlWdata[RST_BIT]) begin
        rstEnQ <= 1'b1;
      end
    end
  end

  // interrupt enable, pending flag and reset pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnQ   <= 1'b0;
      irqFlagQ <= 1'b0;
      sysRstQ  <= 1'b0;
    end else begin
      if (fuseOn || escalate) begin
        intEnQ <= 1'b0;
      end else if (ctlWr) begin
        intEnQ <= ctlWdata[INT_BIT];
      end
      if (fireIrq) begin
        irqFlagQ <= 1'b1;
      end else if (ctlWr && ctlWdata[IRQ_BIT]) begin
        irqFlagQ <= 1'b0;
      end
      sysRstQ <= fireRst;
    end
  end
endmodule

// File: rtl/wdog_flags.sv
module wdog_flags
  import wdog_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               causeWr,
  input  logic [CAUSE_W-1:0] causeWdata,
  input  logic               wdSet,
  input  logic               borEvt,
  input  logic               extEvt,
  input  logic               porEvt,
  output logic [CAUSE_W-1:0] causeRdata
);
  logic [CAUSE_W-1:0] causeQ, setVec, clrVec;

  always_comb begin
    setVec           = '0;
    setVec[WD_FLAG]  = wdSet;
    setVec[BOR_FLAG] = borEvt;
    setVec[EXT_FLAG] = extEvt;
    setVec[POR_FLAG] = porEvt;
    clrVec           = causeWr ? causeWdata : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) causeQ <= '0;
    else       causeQ <= (causeQ & ~clrVec) | setVec;
  end

  assign causeRdata = causeQ;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int NUM_TAPS  = 10,
  parameter int WIN_LEN   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               kick,
  input  logic               fuseOn,
  input  logic               ctlWr,
  input  logic [CTL_W-1:0]   ctlWdata,
  output logic [CTL_W-1:0]   ctlRdata,
  input  logic               causeWr,
  input  logic [CAUSE_W-1:0] causeWdata,
  output logic [CAUSE_W-1:0] causeRdata,
  input  logic               borEvt,
  input  logic               extEvt,
  input  logic               porEvt,
  output logic               irqOut,
  output logic               sysRst
);
  dpCmd_t           cmd;
  logic [SEL_W-1:0] sel;
  logic             expire, wdSet;

  wdog_ctrl #(.WIN_LEN(WIN_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .fuseOn(fuseOn), .kick(kick),
    .ctlWr(ctlWr), .ctlWdata(ctlWdata), .expire(expire),
    .cmd(cmd), .sel(sel), .ctlRdata(ctlRdata),
    .irqOut(irqOut), .sysRst(sysRst), .wdSet(wdSet)
  );

  wdog_dp #(.BASE_LOG2(BASE_LOG2), .NUM_TAPS(NUM_TAPS)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmd(cmd), .sel(sel), .expire(expire)
  );

  wdog_flags u_flags (
    .clk(clk), .rstN(rstN), .causeWr(causeWr), .causeWdata(causeWdata),
    .wdSet(wdSet), .borEvt(borEvt), .extEvt(extEvt), .porEvt(porEvt),
    .causeRdata(causeRdata)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               fuseOn,
  input logic [CTL_W-1:0]   ctlRdata,
  input logic [CAUSE_W-1:0] causeRdata,
  input logic               sysRst
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) sysRst |=> !sysRst); // R5
  AST_RST_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN) sysRst |-> causeRdata[WD_FLAG]); // R12
  AST_NO_RST_WITH_IRQ: assert property (@(posedge clk) disable iff (!rstN) ctlRdata[INT_BIT] |=> !sysRst); // R6
  AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rstN) (!ctlRdata[INT_BIT] && !ctlRdata[RST_BIT]) |=> !sysRst); // R7
  AST_SEL_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rstN) !ctlRdata[CHG_BIT] |=> $stable(ctlRdata[SEL_LSB +: SEL_W])); // R10
  AST_FUSE_LOCKS_MODE: assert property (@(posedge clk) disable iff (!rstN) fuseOn |-> (ctlRdata[RST_BIT] && !ctlRdata[INT_BIT])); // R11
endmodule

bind wdog_core wdog_chk u_chk (
  .clk(clk), .rstN(rstN), .fuseOn(fuseOn),
  .ctlRdata(ctlRdata), .causeRdata(causeRdata), .sysRst(sysRst)
);

// File: tb/wdog_core_tb.sv
module wdog_core_tb;
  localparam int TB_BASE = 3;
  localparam int TB_TAPS = 10;
  localparam int TB_WIN  = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, tickEn, kick, fuseOn, ctlWr, causeWr, borEvt, extEvt, porEvt;
  logic [7:0] ctlWdata, ctlRdata;
  logic [3:0] causeWdata, causeRdata;
  logic       irqOut, sysRst;

  wdog_core #(.BASE_LOG2(TB_BASE), .NUM_TAPS(TB_TAPS), .WIN_LEN(TB_WIN)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .kick(kick), .fuseOn(fuseOn),
    .ctlWr(ctlWr), .ctlWdata(ctlWdata), .ctlRdata(ctlRdata),
    .causeWr(causeWr), .causeWdata(causeWdata), .causeRdata(causeRdata),
    .borEvt(borEvt), .extEvt(extEvt), .porEvt(porEvt),
    .irqOut(irqOut), .sysRst(sysRst)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  // behavioural model of the requirements
  int unsigned mCnt;
  int          mWin;
  logic [3:0]  mSel, mCause;
  logic        mInt, mRst, mIrq, mSys;

  function automatic int tapTicks(input logic [3:0] s);
    int k;
    k = int'(s);
    if (k > TB_TAPS - 1) k = TB_TAPS - 1;
    return 1 << (TB_BASE + k);
  endfunction

  task automatic modelReset();
    mCnt = 0; mWin = 0; mSel = '0; mCause = '0;
    mInt = 0; mRst = 0; mIrq = 0; mSys = 0;
  endtask

  task automatic modelStep();
    logic effI, effR, run, ex, wdS, arm, fin;
    effI = mInt & ~fuseOn;
    effR = mRst | fuseOn;
    run  = effI | effR;
    ex   = run && tickEn && !kick && (mCnt >= 32'(tapTicks(mSel) - 1));
    wdS  = ex && effR && !effI;
    arm  = ctlWr && ctlWdata[6] && ctlWdata[5];
    fin  = ctlWr && !ctlWdata[6] && (mWin != 0);
    mCause = (mCause & ~(causeWr ? causeWdata : 4'h0)) | {wdS, borEvt, extEvt, porEvt};
    if (ex && effI) mIrq = 1'b1; else if (ctlWr && ctlWdata[7]) mIrq = 1'b0;
    if (fuseOn || (ex && effI && effR)) mInt = 1'b0; else if (ctlWr) mInt = ctlWdata[4];
    if (fuseOn) mRst = 1'b1; else if (fin) mRst = ctlWdata[5]; else if (ctlWr && ctlWdata[5]) mRst = 1'b1;
    if (fin) mSel = ctlWdata[3:0];
    if (arm) mWin = TB_WIN; else if (fin) mWin = 0; else if (mWin > 0) mWin = mWin - 1;
    mSys = wdS;
    if (!run || kick || ex) mCnt = 0; else if (tickEn) mCnt = mCnt + 1;
  endtask

  task automatic compareAll();
    logic [7:0] expCtl;
    bit bad;
    bad = 0;
    expCtl = {mIrq, (mWin != 0), (mRst | fuseOn), (mInt & ~fuseOn), mSel};
    nChecks++;
    if (ctlRdata[3:0] !== expCtl[3:0]) begin bad = 1; $display("FAIL R9 select act=%0h exp=%0h", ctlRdata[3:0], expCtl[3:0]); end
    if (ctlRdata[4] !== expCtl[4]) begin bad = 1; $display("FAIL R6 intEn act=%0b exp=%0b", ctlRdata[4], expCtl[4]); end
    if (ctlRdata[5] !== expCtl[5]) begin bad = 1; $display("FAIL R10 rstEn act=%0b exp=%0b", ctlRdata[5], expCtl[5]); end
    if (ctlRdata[6] !== expCtl[6]) begin bad = 1; $display("FAIL R8 chgEn act=%0b exp=%0b", ctlRdata[6], expCtl[6]); end
    if (ctlRdata[7] !== expCtl[7] || irqOut !== mIrq) begin bad = 1; $display("FAIL R4 irq act=%0b/%0b exp=%0b", ctlRdata[7], irqOut, mIrq); end
    if (sysRst !== mSys) begin bad = 1; $display("FAIL R5 sysRst act=%0b exp=%0b", sysRst, mSys); end
    if (causeRdata !== mCause) begin bad = 1; $display("FAIL R12 cause act=%0h exp=%0h", causeRdata, mCause); end
    if (bad) nFail++;
  endtask

  task automatic expectEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    if (rstN) modelStep(); else modelReset();
    #1;
    compareAll();
    ctlWr = 0; causeWr = 0; kick = 0; borEvt = 0; extEvt = 0; porEvt = 0;
  endtask

  task automatic ctlWrite(input logic [7:0] d);
    ctlWr = 1; ctlWdata = d;
    cycle();
  endtask

  task automatic kickOnce();
    kick = 1;
    cycle();
  endtask

  task automatic applyReset(input logic fuse);
    rstN = 0; fuseOn = fuse; tickEn = 0; kick = 0; ctlWr = 0; ctlWdata = '0;
    causeWr = 0; causeWdata = '0; borEvt = 0; extEvt = 0; porEvt = 0;
    repeat (3) cycle();
    rstN = 1;
    cycle();
  endtask

  task automatic randomRun(input int n);
    for (int c = 0; c < n; c++) begin
      int r;
      tickEn = ($urandom % 4) != 0;
      kick   = ($urandom % 200) == 0;
      r = int'($urandom % 8);
      if (mWin != 0 && r < 4) begin
        ctlWr = 1;
        ctlWdata = {1'($urandom % 2), 1'b0, 1'($urandom % 2), 1'($urandom % 2),
                    (r == 0) ? 4'($urandom % 16) : 4'($urandom % 4)};
      end else if (($urandom % 30) == 0) begin
        ctlWr = 1;
        if (r < 3) ctlWdata = {1'($urandom % 2), 2'b11, 1'($urandom % 2), 4'($urandom % 16)};
        else       ctlWdata = 8'($urandom);
      end
      causeWr    = ($urandom % 80) == 0;
      causeWdata = 4'($urandom);
      borEvt     = ($urandom % 300) == 0;
      extEvt     = ($urandom % 300) == 0;
      porEvt     = ($urandom % 300) == 0;
      cycle();
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    void'($urandom(32'd7151));
    applyReset(1'b0);
    expectEq("R1 ctl", int'(ctlRdata), 'h00);
    expectEq("R1 cause", int'(causeRdata), 0);
    expectEq("R1 outputs", int'({irqOut, sysRst}), 0);

    // R2: code 0 expires after 2^3 ticks
    ctlWrite(8'h10);
    kickOnce();
    tickEn = 1;
    repeat (7) cycle();
    expectEq("R2 before limit", int'(irqOut), 0);
    cycle();
    expectEq("R2 at limit", int'(irqOut), 1);

    // R4: acknowledge
    tickEn = 0;
    ctlWrite(8'h90);
    expectEq("R4 ack", int'(ctlRdata), 'h10);

    // R3: kick on the final tick
    kickOnce();
    tickEn = 1;
    repeat (7) cycle();
    kick = 1;
    cycle();
    expectEq("R3 kick on last tick", int'(irqOut), 0);
    repeat (7) cycle();
    expectEq("R3 restarted count", int'(irqOut), 0);
    cycle();
    expectEq("R3 full period", int'(irqOut), 1);

    // R8 / R9: timed change to code 2 in interrupt-then-reset mode
    tickEn = 0;
    ctlWrite(8'h90);
    ctlWrite(8'h70);
    expectEq("R8 armed", int'(ctlRdata), 'h70);
    ctlWrite(8'h32);
    expectEq("R9 applied", int'(ctlRdata), 'h32);

    // R6: escalation
    kickOnce();
    tickEn = 1;
    repeat (32) cycle();
    expectEq("R6 first expiry", int'(ctlRdata), 'hA2);
    expectEq("R6 no reset yet", int'(sysRst), 0);
    repeat (31) cycle();
    expectEq("R6 before second", int'(sysRst), 0);
    cycle();
    expectEq("R6 second expiry resets", int'(sysRst), 1);
    expectEq("R5 flag", int'(causeRdata[3]), 1);
    cycle();
    expectEq("R5 single pulse", int'(sysRst), 0);
    expectEq("R5 stays enabled", int'(ctlRdata[5]), 1);

    // R10: unguarded write
    tickEn = 0;
    ctlWrite(8'h05);
    expectEq("R10 ignored", int'(ctlRdata), 'hA2);

    // R8: window expiry
    ctlWrite(8'h60);
    expectEq("R8 open", int'(ctlRdata[6]), 1);
    repeat (3) cycle();
    expectEq("R8 last open clock", int'(ctlRdata[6]), 1);
    cycle();
    expectEq("R8 self clear", int'(ctlRdata[6]), 0);
    ctlWrite(8'h00);
    expectEq("R10 late write", int'(ctlRdata), 'hA2);

    // R13: shorter time-out past current count
    ctlWrite(8'h80);
    ctlWrite(8'h60);
    ctlWrite(8'h25);
    kickOnce();
    tickEn = 1;
    repeat (100) cycle();
    tickEn = 0;
    ctlWrite(8'h60);
    ctlWrite(8'h20);
    expectEq("R13 no early reset", int'(sysRst), 0);
    tickEn = 1;
    cycle();
    expectEq("R13 immediate expiry", int'(sysRst), 1);

    // R7: disabled
    tickEn = 0;
    ctlWrite(8'h60);
    ctlWrite(8'h00);
    tickEn = 1;
    repeat (600) cycle();
    expectEq("R7 quiet", int'({ctlRdata, irqOut, sysRst}), 0);

    // R12: cause flags
    causeWr = 1; causeWdata = 4'hF;
    cycle();
    expectEq("R12 cleared", int'(causeRdata), 0);
    borEvt = 1;
    cycle();
    extEvt = 1; porEvt = 1;
    cycle();
    expectEq("R12 set", int'(causeRdata), 'h7);
    causeWr = 1; causeWdata = 4'h5; borEvt = 1;
    cycle();
    expectEq("R12 set beats clear", int'(causeRdata), 'h6);

    // R2: code 12 acts as code 9
    tickEn = 0;
    ctlWrite(8'h60);
    ctlWrite(8'h1C);
    kickOnce();
    tickEn = 1;
    repeat (4095) cycle();
    expectEq("R2 clamp before", int'(irqOut), 0);
    cycle();
    expectEq("R2 clamp at limit", int'(irqOut), 1);

    // R11: fuse
    applyReset(1'b1);
    expectEq("R11 reset view", int'(ctlRdata), 'h20);
    ctlWrite(8'h10);
    expectEq("R11 intEn locked", int'(ctlRdata), 'h20);
    ctlWrite(8'h60);
    ctlWrite(8'h03);
    expectEq("R11 rstEn locked", int'(ctlRdata), 'h23);
    kickOnce();
    tickEn = 1;
    repeat (63) cycle();
    expectEq("R11 before", int'(sysRst), 0);
    cycle();
    expectEq("R11 forced reset", int'(sysRst), 1);

    randomRun(2000);
    applyReset(1'b0);
    randomRun(8000);
    report();
  end
endmodule